// File: doc/BRIEF.md
# Banked GPIO interrupt controller

This block manages sixty-four general-purpose pins arranged as four banks of sixteen. For each pin it holds a direction bit, an output value and an alternate-function select bit. It also detects interrupt events on the pin. Every pin input passes through a two-flop synchronizer. A pin can trigger on an edge or on a level. In edge mode, a polarity bit chooses between the rising and the falling edge. In level mode, a second polarity bit chooses between active-high and active-low. A detected event that is not masked is latched into the bank's status register. Software clears that register by writing to it.

A top-level pending register collects one flag per bank in its low bits, and six synchronized peripheral interrupt lines above them. A global control register holds one enable bit per peripheral line and a global enable bit. The single host interrupt output is registered. It is driven by a two-state machine with the states IRQ_IDLE and IRQ_RAISED. The transition IRQ_IDLE to IRQ_RAISED is taken when the global enable is set and any unmasked bank flag or enabled peripheral line is active. The transition IRQ_RAISED to IRQ_IDLE is taken when that request disappears. A separate registered wake output reports latched status bits that the per-bank sleep mask does not exclude.

Both-edge detection is left to software. After each event, software inverts the pin's edge polarity bit, so the hardware only ever watches for one polarity.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every bank's interrupt mask reads 0xFFFF. Every other register reads 0, and host_irq and wake_req are 0.
- R2: Pin n belongs to bank n/16 at bit n%16. Bus address bits [7:4] select the bank (0 to 3) and bits [3:0] select the register: 0 direction, 1 output value, 2 pin level (read-only), 3 alternate select, 4 mask, 5 trigger type, 6 edge polarity, 7 level polarity, 8 sleep mask, 9 latched status. pin_oe follows the direction bits (1 = output), pin_out follows the output register, and alt_sel follows the alternate-select register.
- R3: The pin-level register returns pin_in after a two-flop synchronizer.
- R4: With trigger-type bit 1 (edge mode), edge polarity 1 latches a rising edge and 0 latches a falling edge. The status bit stays set after the pin returns.
- R5: With trigger-type bit 0 (level mode), level polarity 1 means active-high and 0 means active-low. The status bit sets again in every cycle that the pin is active, so a clear has no lasting effect while the pin is active.
- R6: A pin whose mask bit is 1 never sets its status bit.
- R7: A write to the status register keeps only the bits that are 1 in the written data. Writing 0 clears the whole register, and a new event in the same cycle takes priority over the clear.
- R8: Address 0xF0 is the read-only pending register. Bits 0 to 3 are the OR of each bank's unmasked status, and bits 4 to 9 are the synchronized ext_irq lines.
- R9: Address 0xF1 is the global control register. Bits 5:0 enable the ext_irq lines and bit 15 is the global enable. host_irq is a registered OR of the bank flags and the enabled ext lines, gated by bit 15.
- R10: wake_req is a registered OR of latched status bits whose sleep-mask bit is 0.
- R11: Inverting a pin's edge polarity after an event makes the next event of the opposite direction latch, which gives both-edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| pin_in | input | 64 | Pin levels from the pads |
| pin_out | output | 64 | Output values |
| pin_oe | output | 64 | Output enables |
| alt_sel | output | 64 | Alternate-function selects |
| ext_irq | input | 6 | Peripheral interrupt lines |
| host_irq | output | 1 | Interrupt to the host |
| wake_req | output | 1 | Wake request |

## Verification
The edge assertion compares the synchronized level with its delayed copy. It therefore assumes that pin_in holds a constant low value through reset, so that no false edge appears when reset is released. The bench drives every pin to 0 during reset. It changes pins and ext lines only on falling clock edges, and it leaves at least six cycles before each check, which covers the synchronizer, the status latch and the output register. Register writes are single-cycle strobes, so the masks always hold a defined value.

// File: rtl/gic_pkg.sv
package gic_pkg;

    typedef enum logic [3:0] {
        OFF_DIR   = 4'd0,
        OFF_OUT   = 4'd1,
        OFF_PIN   = 4'd2,
        OFF_ALT   = 4'd3,
        OFF_MASK  = 4'd4,
        OFF_TRIG  = 4'd5,
        OFF_EDGE  = 4'd6,
        OFF_LVL   = 4'd7,
        OFF_SLEEP = 4'd8,
        OFF_STAT  = 4'd9
    } bank_off_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam logic [3:0] TOP_SEL   = 4'hF;
    localparam logic [3:0] TOP_PEND  = 4'h0;
    localparam logic [3:0] TOP_GCTL  = 4'h1;
    localparam int         GEN_BIT   = 15;
    localparam int         BUS_W     = 16;

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gic_bank.sv
module gic_bank
    import gic_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   off,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_lvl,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] alt_o,
    output logic         pend_o,
    output logic         wake_o
);
    logic [W-1:0] dir_r, out_r, alt_r, mask_r, trig_r;
    logic [W-1:0] edge_r, lvl_r, sleep_r, stat_r, prev_r;
    logic [W-1:0] edge_hit, lvl_hit, set_v, stat_kept, stat_next;

    // event detection
    always_comb begin
        edge_hit  = trig_r & ((edge_r & pin_lvl & ~prev_r) |
                              (~edge_r & ~pin_lvl & prev_r));
        lvl_hit   = ~trig_r & ~(pin_lvl ^ lvl_r);
        set_v     = (edge_hit | lvl_hit) & ~mask_r;
        stat_kept = (wr_en && off == OFF_STAT) ? (stat_r & wdata) : stat_r;
        stat_next = stat_kept | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_r   <= '0;
            out_r   <= '0;
            alt_r   <= '0;
            mask_r  <= '1;
            trig_r  <= '0;
            edge_r  <= '0;
            lvl_r   <= '0;
            sleep_r <= '0;
            stat_r  <= '0;
            prev_r  <= '0;
        end else begin
            if (wr_en) begin
                case (off)
                    OFF_DIR:   dir_r   <= wdata;
                    OFF_OUT:   out_r   <= wdata;
                    OFF_ALT:   alt_r   <= wdata;
                    OFF_MASK:  mask_r  <= wdata;
                    OFF_TRIG:  trig_r  <= wdata;
                    OFF_EDGE:  edge_r  <= wdata;
                    OFF_LVL:   lvl_r   <= wdata;
                    OFF_SLEEP: sleep_r <= wdata;
                    default:   ;
                endcase
            end
            stat_r <= stat_next;
            prev_r <= pin_lvl;
        end
    end

    always_comb begin
        case (off)
            OFF_DIR:   rdata = dir_r;
            OFF_OUT:   rdata = out_r;
            OFF_PIN:   rdata = pin_lvl;
            OFF_ALT:   rdata = alt_r;
            OFF_MASK:  rdata = mask_r;
            OFF_TRIG:  rdata = trig_r;
            OFF_EDGE:  rdata = edge_r;
            OFF_LVL:   rdata = lvl_r;
            OFF_SLEEP: rdata = sleep_r;
            OFF_STAT:  rdata = stat_r;
            default:   rdata = '0;
        endcase
    end

    assign dir_o  = dir_r;
    assign out_o  = out_r;
    assign alt_o  = alt_r;
    assign pend_o = |(stat_r & ~mask_r);
    assign wake_o = |(stat_r & ~sleep_r);

    // R6
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_r & ~$past(stat_r) & $past(mask_r)) == '0);

    // R4
    edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_r & ~$past(stat_r) & $past(trig_r) &
         ~($past(pin_lvl) ^ $past(prev_r))) == '0);
endmodule

// File: rtl/gic_irq_out.sv
module gic_irq_out
    import gic_pkg::*;
#(
    parameter int NB = 4,
    parameter int NE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank_pend,
    input  logic [NE-1:0] ext_lvl,
    input  logic [NE-1:0] ext_en,
    input  logic          gen,
    input  logic          wake_any,
    output logic          host_irq,
    output logic          wake_req
);
    irq_state_e state_q, state_d;
    logic       req;

    assign req = gen && ((|bank_pend) || (|(ext_lvl & ext_en)));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (req)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!req) state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= wake_any;
    end

    assign host_irq = (state_q == IRQ_RAISED);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(gen));

    // R10
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(wake_any));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gic_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 16,
    parameter int NUM_EXT   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  bus_addr,
    input  logic                        bus_we,
    input  logic [15:0]                 bus_wdata,
    output logic [15:0]                 bus_rdata,
    input  logic [NUM_BANKS*PINS-1:0]   pin_in,
    output logic [NUM_BANKS*PINS-1:0]   pin_out,
    output logic [NUM_BANKS*PINS-1:0]   pin_oe,
    output logic [NUM_BANKS*PINS-1:0]   alt_sel,
    input  logic [NUM_EXT-1:0]          ext_irq,
    output logic                        host_irq,
    output logic                        wake_req
);
    localparam int NPIN   = NUM_BANKS * PINS;
    localparam int PEND_W = NUM_BANKS + NUM_EXT;

    logic [NPIN-1:0]      pin_s;
    logic [NUM_EXT-1:0]   ext_s;
    logic [PINS-1:0]      bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_pend, bank_wake;
    logic [NUM_EXT-1:0]   ext_en_r;
    logic                 gen_r;
    logic [3:0]           sel, off;
    logic [PEND_W-1:0]    pend_vec;

    assign sel = bus_addr[7:4];
    assign off = bus_addr[3:0];

    gic_sync #(.W(NPIN), .STAGES(2)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pin_s));

    gic_sync #(.W(NUM_EXT), .STAGES(2)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ext_irq), .q_out(ext_s));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gic_bank #(.W(PINS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we && (sel == 4'(b))),
            .off    (off),
            .wdata  (bus_wdata[PINS-1:0]),
            .pin_lvl(pin_s[b*PINS +: PINS]),
            .rdata  (bank_rd[b]),
            .dir_o  (pin_oe[b*PINS +: PINS]),
            .out_o  (pin_out[b*PINS +: PINS]),
            .alt_o  (alt_sel[b*PINS +: PINS]),
            .pend_o (bank_pend[b]),
            .wake_o (bank_wake[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_en_r <= '0;
            gen_r    <= 1'b0;
        end else if (bus_we && sel == TOP_SEL && off == TOP_GCTL) begin
            ext_en_r <= bus_wdata[NUM_EXT-1:0];
            gen_r    <= bus_wdata[GEN_BIT];
        end
    end

    assign pend_vec = {ext_s, bank_pend};

    always_comb begin
        bus_rdata = '0;
        if (sel == TOP_SEL) begin
            if (off == TOP_PEND) begin
                bus_rdata[PEND_W-1:0] = pend_vec;
            end else if (off == TOP_GCTL) begin
                bus_rdata[NUM_EXT-1:0] = ext_en_r;
                bus_rdata[GEN_BIT]     = gen_r;
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (sel == 4'(b)) bus_rdata[PINS-1:0] = bank_rd[b];
            end
        end
    end

    gic_irq_out #(.NB(NUM_BANKS), .NE(NUM_EXT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_pend(bank_pend),
        .ext_lvl  (ext_s),
        .ext_en   (ext_en_r),
        .gen      (gen_r),
        .wake_any (|bank_wake),
        .host_irq (host_irq),
        .wake_req (wake_req)
    );
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe, alt_sel;
    logic [5:0]  ext_irq = '0;
    logic        host_irq, wake_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
        .ext_irq(ext_irq), .host_irq(host_irq), .wake_req(wake_req));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int b = 0; b < 4; b++) begin
            rd(8'(b * 16 + 4), v);
            chk("R1 mask", v, 16'hFFFF);
            rd(8'(b * 16 + 9), v);
            chk("R1 status", v, 16'h0);
        end
        rd(8'hF0, v); chk("R1 pending", v, 16'h0);
        rd(8'hF1, v); chk("R1 gctl", v, 16'h0);
        chk("R1 host_irq", host_irq, 0);
        chk("R1 wake_req", wake_req, 0);
    endtask

    task automatic t_dir_out();
        logic [15:0] v;
        wr(8'h10, 16'h00F0);
        wr(8'h11, 16'h0050);
        wr(8'h33, 16'h8001);
        settle();
        chk("R2 pin_oe", pin_oe, 64'h0000_0000_00F0_0000);
        chk("R2 pin_out", pin_out, 64'h0000_0000_0050_0000);
        chk("R2 alt_sel", alt_sel, 64'h8001_0000_0000_0000);
        rd(8'h10, v); chk("R2 dir readback", v, 16'h00F0);
    endtask

    task automatic t_pin_read();
        logic [15:0] v;
        @(negedge clk); pin_in[47:32] = 16'hA5C3;
        rd(8'h22, v); chk("R3 not yet synced", v, 16'h0000);
        settle();
        rd(8'h22, v); chk("R3 pin level", v, 16'hA5C3);
        @(negedge clk); pin_in[47:32] = 16'h0;
        settle();
    endtask

    task automatic t_edge();
        logic [15:0] v;
        wr(8'h15, 16'h0008);
        wr(8'h16, 16'h0008);
        wr(8'h14, 16'hFFF7);
        @(negedge clk); pin_in[19] = 1'b1; settle();
        rd(8'h19, v); chk("R4 rising latched", v, 16'h0008);
        chk("R9 no irq without global enable", host_irq, 0);
        @(negedge clk); pin_in[19] = 1'b0; settle();
        rd(8'h19, v); chk("R4 stays latched", v, 16'h0008);
        wr(8'h19, 16'h0000); settle();
        rd(8'h19, v); chk("R7 clear by zero", v, 16'h0000);
        wr(8'h16, 16'h0000);
        @(negedge clk); pin_in[19] = 1'b1; settle();
        rd(8'h19, v); chk("R4 falling mode ignores rise", v, 16'h0000);
        @(negedge clk); pin_in[19] = 1'b0; settle();
        rd(8'h19, v); chk("R4 falling latched", v, 16'h0008);
        wr(8'h19, 16'h0000);
        wr(8'h14, 16'hFFFF);
    endtask

    task automatic t_level();
        logic [15:0] v;
        wr(8'h27, 16'h0020);
        wr(8'h24, 16'hFFDF);
        settle();
        rd(8'h29, v); chk("R5 inactive high-level", v, 16'h0000);
        @(negedge clk); pin_in[37] = 1'b1; settle();
        rd(8'h29, v); chk("R5 active high", v, 16'h0020);
        wr(8'h29, 16'h0000); settle();
        rd(8'h29, v); chk("R5 re-asserts after clear", v, 16'h0020);
        @(negedge clk); pin_in[37] = 1'b0; settle();
        rd(8'h29, v); chk("R5 latched after release", v, 16'h0020);
        wr(8'h29, 16'h0000); settle();
        rd(8'h29, v); chk("R7 clear when inactive", v, 16'h0000);
        wr(8'h27, 16'h0000); settle();
        rd(8'h29, v); chk("R5 active low", v, 16'h0020);
        wr(8'h24, 16'hFFFF);
        wr(8'h29, 16'h0000); settle();
        rd(8'h29, v); chk("R6 masked level stays clear", v, 16'h0000);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(8'h35, 16'hFFFF);
        wr(8'h36, 16'hFFFF);
        @(negedge clk); pin_in[63:48] = 16'hFFFF; settle();
        rd(8'h39, v); chk("R6 masked edges", v, 16'h0000);
        rd(8'hF0, v); chk("R6 no bank pending", v, 16'h0000);
        @(negedge clk); pin_in[63:48] = 16'h0; settle();
    endtask

    task automatic t_partial_clear();
        logic [15:0] v;
        wr(8'h05, 16'h0003);
        wr(8'h06, 16'h0003);
        wr(8'h04, 16'hFFFC);
        @(negedge clk); pin_in[1:0] = 2'b11; settle();
        rd(8'h09, v); chk("R4 two pins latched", v, 16'h0003);
        wr(8'h09, 16'h0002); settle();
        rd(8'h09, v); chk("R7 keep only written ones", v, 16'h0002);
        wr(8'h09, 16'h0000);
        @(negedge clk); pin_in[1:0] = 2'b00; settle();
        wr(8'h04, 16'hFFFF);
    endtask

    task automatic t_top_irq();
        logic [15:0] v;
        wr(8'h05, 16'h0001);
        wr(8'h06, 16'h0001);
        wr(8'h04, 16'hFFFE);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(8'hF0, v); chk("R8 bank0 pending", v, 16'h0001);
        chk("R9 gated off", host_irq, 0);
        wr(8'hF1, 16'h8000); settle();
        chk("R9 irq on global enable", host_irq, 1);
        wr(8'h09, 16'h0000); settle();
        chk("R9 irq drops after clear", host_irq, 0);
        @(negedge clk); ext_irq[2] = 1'b1; settle();
        rd(8'hF0, v); chk("R8 ext line bit6", v, 16'h0040);
        chk("R9 ext not enabled", host_irq, 0);
        wr(8'hF1, 16'h8004); settle();
        chk("R9 ext enabled", host_irq, 1);
        wr(8'hF1, 16'h0004); settle();
        chk("R9 global enable off", host_irq, 0);
        @(negedge clk); ext_irq[2] = 1'b0; pin_in[0] = 1'b0; settle();
        wr(8'h04, 16'hFFFF);
    endtask

    task automatic t_wake();
        wr(8'h05, 16'h0004);
        wr(8'h06, 16'h0004);
        wr(8'h04, 16'hFFFB);
        @(negedge clk); pin_in[2] = 1'b1; settle();
        chk("R10 wake from status", wake_req, 1);
        wr(8'h08, 16'h0004); settle();
        chk("R10 sleep mask excludes", wake_req, 0);
        wr(8'h09, 16'h0000);
        wr(8'h08, 16'h0000); settle();
        chk("R10 no wake after clear", wake_req, 0);
        @(negedge clk); pin_in[2] = 1'b0; settle();
        wr(8'h04, 16'hFFFF);
    endtask

    task automatic t_both_edge();
        logic [15:0] v;
        wr(8'h05, 16'h0010);
        wr(8'h06, 16'h0010);
        wr(8'h04, 16'hFFEF);
        @(negedge clk); pin_in[4] = 1'b1; settle();
        rd(8'h09, v); chk("R11 first rising", v, 16'h0010);
        wr(8'h06, 16'h0000);
        wr(8'h09, 16'h0000); settle();
        rd(8'h09, v); chk("R11 cleared after flip", v, 16'h0000);
        @(negedge clk); pin_in[4] = 1'b0; settle();
        rd(8'h09, v); chk("R11 opposite edge latched", v, 16'h0010);
        wr(8'h04, 16'hFFFF);
        wr(8'h09, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_dir_out();
        t_pin_read();
        t_edge();
        t_level();
        t_mask();
        t_partial_clear();
        t_top_irq();
        t_wake();
        t_both_edge();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule